// File: doc/BRIEF.md
# Chained Watch Timer Unit

A three-counter timing block for a low-power watch controller. The first counter is a free-running 8-bit prescaler that advances on each rising edge of the 32768 Hz crystal signal. It raises a request flag on every carry out, which happens 128 times a second. The second and third counters have a programmable modulus. Each takes its count events from a source chosen in a control register: the prescaler carry, a 2048 Hz tap of the prescaler, a fast tone clock, an external input, or, for the third counter, the clear pulse of the second. When a modulus counter reaches its modulus it clears and raises its own flag.

All asynchronous inputs are synchronized to the system clock and turned into single-cycle enables, so the whole unit runs on one clock. Software reaches the block over a plain register bus with address, write data, write strobe and a combinational read path. The three request flags are also driven straight out as pins.

Register map (3-bit address): 0 control, 1 prescaler count (read-only), 2 second counter (read-only), 3 third counter (read-only), 4 second modulus, 5 third modulus, 6 flag register. All other addresses read as zero.

Top module: `tick_chain_timer`

## Requirements
- R1: After reset every register reads 0x00 and all three flag pins are low. With control at 0x00 neither modulus counter advances.
- R2: The prescaler (address 1) adds one on each synchronized rising edge of `xtal` and wraps 255 to 0. A bus write to address 1 has no effect on it.
- R3: Flag register (address 6) layout: bit 7 is the carry mask, bit 2 is flag 3, bit 1 is flag 2, bit 0 is flag 1. Flag 1 is set when the prescaler steps from 255 to 0 while the mask is 0. Setting the mask keeps the current flag 1 value and blocks later settings. Writing 0 to a flag bit clears that flag, and writing 1 leaves it as it is.
- R4: A modulus counter that takes an event while its count plus one equals its modulus register goes to 0 and emits a clear pulse that sets its flag. A modulus of 0x00 divides by 256.
- R5: Control bits 5:4 pick the source for the second counter: 00 prescaler carry, 01 the cycle in which prescaler bit 3 rises (2048 Hz), 10 tone clock edges, 11 an external input (`in6` when not chained).
- R6: Control bits 7:6 pick the source for the third counter: 00 prescaler carry, 01 the 2048 Hz tap, 10 the second counter's clear pulse (chained mode), 11 `in6` edges.
- R7: In tone mode (bits 5:4 = 10) the second counter wraps freely with no modulus compare, and flag 2 is never set.
- R8: Control bit 2 clears the second counter, holds it at 0 and resets flag 2 while it is set. Control bit 3 does the same for the third counter and flag 3 when not in chained mode.
- R9: Control bit 0 enables the second counter. Control bit 1 enables the third counter when not in chained mode. A disabled counter holds its value.
- R10: In chained mode flag 2 is never set. Bit 0 gates both counters and bit 1 enables nothing. Bit 2 also clears the third counter and resets flag 3.
- R11: In chained mode control bits {3,1} pick the second counter's external input (bits 5:4 = 11): 00 `in7`, 01 `in6`, 1x `in8`. An input that is not selected has no effect.
- R12: While `halt` is high the prescaler is held at zero and ignores crystal edges. It resumes counting from zero once `halt` is released.
- R13: Pins `fr1`, `fr2`, `fr3` always equal flag register bits 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt | input | 1 | Holds the prescaler at zero |
| xtal | input | 1 | 32768 Hz crystal signal (asynchronous) |
| tone_clk | input | 1 | Tone-mode count clock (asynchronous) |
| in6 | input | 1 | External count input (asynchronous) |
| in7 | input | 1 | External count input, chained mode (asynchronous) |
| in8 | input | 1 | External count input, chained mode (asynchronous) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe, one cycle per write |
| rdata | output | 8 | Read data for `addr` |
| fr1 | output | 1 | Prescaler carry flag |
| fr2 | output | 1 | Second counter flag |
| fr3 | output | 1 | Third counter flag |

## Verification
The prescaler is driven with crystal bursts sized to land just before and across its carry. This separates a correct carry flag from one raised on another count, and it shows whether the mask blocks a new setting without erasing an existing one. The second counter is run from the 2048 Hz tap, from external pulses with modulus 0 (255 versus 256 events tells wrap-clear from compare-clear), and from the tone clock, where a count beyond the modulus proves that the compare is bypassed. Chained runs feed one selected input while toggling the others, so they reveal a wrong input-select decode, a missing chained-mode inhibit of flag 2, and whether the control bits still gate both counters.

// File: rtl/tick_chain_timer.sv
module tick_chain_timer #(
  parameter int W   = 8,
  parameter int AW  = 3,
  parameter int TAP = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          xtal,
  input  logic          tone_clk,
  input  logic          in6,
  input  logic          in7,
  input  logic          in8,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  input  logic          wr_en,
  output logic [W-1:0]  rdata,
  output logic          fr1,
  output logic          fr2,
  output logic          fr3
);
  localparam int NI = 5;
  localparam logic [AW-1:0] A_CTL = AW'(0), A_T1 = AW'(1), A_T2 = AW'(2),
                            A_T3 = AW'(3), A_K2 = AW'(4), A_K3 = AW'(5), A_FLG = AW'(6);
  localparam logic [TAP:0] TAP_PRE = {1'b0, {TAP{1'b1}}};

  logic [NI-1:0] s1, s2, s3, edg;
  logic [7:0]    ctl_q;
  logic [W-1:0]  t1_q, t2_q, t3_q, kt2_q, kt3_q, nxt2, nxt3;
  logic          mfr1_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1 <= '0; s2 <= '0; s3 <= '0;
    end else begin
      s1 <= {in8, in7, in6, tone_clk, xtal};
      s2 <= s1;
      s3 <= s2;
    end
  assign edg = s2 & ~s3;

  logic tick, tone_e, e6, e7, e8;
  assign {e8, e7, e6, tone_e, tick} = edg;

  logic frt1, s2k, chained, tone, en2, en3, clr2, clr3;
  assign frt1    = tick && !halt && (t1_q == '1);
  assign s2k     = tick && !halt && (t1_q[TAP:0] == TAP_PRE);
  assign chained = ctl_q[7:6] == 2'b10;
  assign tone    = ctl_q[5:4] == 2'b10;
  assign en2     = ctl_q[0];
  assign en3     = chained ? ctl_q[0] : ctl_q[1];
  assign clr2    = ctl_q[2];
  assign clr3    = chained ? ctl_q[2] : ctl_q[3];

  logic ext2, src2, src3;
  always_comb begin
    if (!chained)        ext2 = e6;
    else if (ctl_q[3])   ext2 = e8;
    else if (ctl_q[1])   ext2 = e6;
    else                 ext2 = e7;
    case (ctl_q[5:4])
      2'b00:   src2 = frt1;
      2'b01:   src2 = s2k;
      2'b10:   src2 = tone_e;
      default: src2 = ext2;
    endcase
  end

  logic step2, hit2, step3, hit3;
  assign nxt2  = t2_q + W'(1);
  assign nxt3  = t3_q + W'(1);
  assign step2 = en2 && src2 && !clr2;
  assign hit2  = step2 && !tone && (nxt2 == kt2_q);

  always_comb
    case (ctl_q[7:6])
      2'b00:   src3 = frt1;
      2'b01:   src3 = s2k;
      2'b10:   src3 = hit2;
      default: src3 = e6;
    endcase
  assign step3 = en3 && src3 && !clr3;
  assign hit3  = step3 && (nxt3 == kt3_q);

  logic wflg;
  assign wflg = wr_en && (addr == A_FLG);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctl_q <= '0; kt2_q <= '0; kt3_q <= '0; mfr1_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CTL) ctl_q  <= wdata[7:0];
      if (addr == A_K2)  kt2_q  <= wdata;
      if (addr == A_K3)  kt3_q  <= wdata;
      if (wflg)          mfr1_q <= wdata[W-1];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      t1_q <= '0; t2_q <= '0; t3_q <= '0;
    end else begin
      if (halt)      t1_q <= '0;
      else if (tick) t1_q <= t1_q + W'(1);
      if (clr2)       t2_q <= '0;
      else if (hit2)  t2_q <= '0;
      else if (step2) t2_q <= nxt2;
      if (clr3)       t3_q <= '0;
      else if (hit3)  t3_q <= '0;
      else if (step3) t3_q <= nxt3;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fr1 <= 1'b0; fr2 <= 1'b0; fr3 <= 1'b0;
    end else begin
      if (frt1 && !mfr1_q)        fr1 <= 1'b1;
      else if (wflg && !wdata[0]) fr1 <= 1'b0;
      if (clr2)                   fr2 <= 1'b0;
      else if (hit2 && !chained)  fr2 <= 1'b1;
      else if (wflg && !wdata[1]) fr2 <= 1'b0;
      if (clr3)                   fr3 <= 1'b0;
      else if (hit3)              fr3 <= 1'b1;
      else if (wflg && !wdata[2]) fr3 <= 1'b0;
    end

  always_comb
    case (addr)
      A_CTL:   rdata = W'(ctl_q);
      A_T1:    rdata = t1_q;
      A_T2:    rdata = t2_q;
      A_T3:    rdata = t3_q;
      A_K2:    rdata = kt2_q;
      A_K3:    rdata = kt3_q;
      A_FLG:   rdata = {mfr1_q, (W-4)'(0), fr3, fr2, fr1};
      default: rdata = '0;
    endcase
endmodule

// File: rtl/tick_chain_timer_chk.sv
module tick_chain_timer_chk #(parameter int W = 8) (
  input logic         clk,
  input logic         rst_n,
  input logic         halt,
  input logic         tick,
  input logic [7:0]   ctl_q,
  input logic [W-1:0] t1_q,
  input logic [W-1:0] t2_q,
  input logic         mfr1_q,
  input logic         fr1,
  input logic         fr2
);
  // R12
  halt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> t1_q == '0);
  // R2
  t1_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!halt && !tick) |=> $stable(t1_q));
  // R8
  t2_clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[2] |=> t2_q == '0);
  // R8
  fr2_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[2] |=> !fr2);
  // R3
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mfr1_q && !fr1) |=> !fr1);
  // R7
  tone_no_fr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[5:4] == 2'b10 && !fr2) |=> !fr2);
  // R10
  chain_no_fr2_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[7:6] == 2'b10 && !fr2) |=> !fr2);
endmodule

bind tick_chain_timer tick_chain_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .halt(halt), .tick(tick), .ctl_q(ctl_q),
  .t1_q(t1_q), .t2_q(t2_q), .mfr1_q(mfr1_q), .fr1(fr1), .fr2(fr2)
);

// File: tb/tick_chain_timer_tb.sv
module tick_chain_timer_tb;
  logic clk = 1'b0, rst_n = 1'b0, halt = 1'b0, wr_en = 1'b0;
  logic [4:0] pin_in = '0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic fr1, fr2, fr3;
  int n_chk = 0, n_fail = 0;
  logic chk = 1'b0, pin_mode = 1'b0, done = 1'b0;
  logic [7:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  tick_chain_timer u_dut (
    .clk(clk), .rst_n(rst_n), .halt(halt), .xtal(pin_in[0]), .tone_clk(pin_in[1]),
    .in6(pin_in[2]), .in7(pin_in[3]), .in8(pin_in[4]), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rdata(rdata), .fr1(fr1), .fr2(fr2), .fr3(fr3));

  always @(negedge clk)
    if (chk && exp_q.size() > 0) begin
      logic [7:0] act, exp;
      string tag;
      act = pin_mode ? {5'b0, fr3, fr2, fr1} : rdata;
      exp = exp_q.pop_front();
      tag = tag_q.pop_front();
      n_chk++;
      if (act !== exp) begin
        n_fail++;
        $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
    end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1 addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1 wr_en = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  task automatic expect_rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    @(posedge clk); #1 addr = a; pin_mode = 1'b0;
    exp_q.push_back(e); tag_q.push_back(tag); chk = 1'b1;
    @(negedge clk); #1 chk = 1'b0;
  endtask

  task automatic expect_pins(input logic [2:0] e, input string tag);
    @(posedge clk); #1 pin_mode = 1'b1;
    exp_q.push_back({5'b0, e}); tag_q.push_back(tag); chk = 1'b1;
    @(negedge clk); #1 chk = 1'b0; pin_mode = 1'b0;
  endtask

  // which: 0 xtal, 1 tone_clk, 2 in6, 3 in7, 4 in8
  task automatic kick(input int which, input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 pin_in[which] = 1'b1;
      repeat (3) @(posedge clk);
      #1 pin_in[which] = 1'b0;
      repeat (3) @(posedge clk);
    end
    repeat (6) @(posedge clk);
  endtask

  task automatic zero_t1();
    @(posedge clk); #1 halt = 1'b1;
    repeat (3) @(posedge clk);
    #1 halt = 1'b0;
    repeat (2) @(posedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1 reset state
    for (int a = 0; a < 7; a++) expect_rd(3'(a), 8'h00, "R1 reset register");
    expect_pins(3'b000, "R1/R13 reset pins");
    kick(2, 3);
    expect_rd(3'd2, 8'h00, "R1 idle T2");
    expect_rd(3'd3, 8'h00, "R1 idle T3");
    // R2 prescaler count, read-only
    kick(0, 5);
    expect_rd(3'd1, 8'h05, "R2 prescaler count");
    wr(3'd1, 8'hAA);
    expect_rd(3'd1, 8'h05, "R2 write ignored");
    // R12 halt
    @(posedge clk); #1 halt = 1'b1;
    kick(0, 3);
    expect_rd(3'd1, 8'h00, "R12 held at zero");
    #1 halt = 1'b0;
    kick(0, 2);
    expect_rd(3'd1, 8'h02, "R12 resume");
    // R3 carry flag and mask
    kick(0, 253);
    expect_rd(3'd6, 8'h00, "R3 no flag before carry");
    kick(0, 1);
    expect_rd(3'd1, 8'h00, "R2 wrap");
    expect_rd(3'd6, 8'h01, "R3 carry flag set");
    expect_pins(3'b001, "R13 fr1 pin");
    wr(3'd6, 8'h81);
    expect_rd(3'd6, 8'h81, "R3 mask keeps flag");
    wr(3'd6, 8'h80);
    expect_rd(3'd6, 8'h80, "R3 write-zero clears");
    kick(0, 256);
    expect_rd(3'd6, 8'h80, "R3 masked carry blocked");
    wr(3'd6, 8'h00);
    // R5/R4 2048 Hz source, modulus 3
    zero_t1();
    wr(3'd4, 8'd3);
    wr(3'd0, 8'h11);
    kick(0, 112);
    expect_rd(3'd2, 8'h01, "R5 2048Hz source R4 modulus");
    expect_rd(3'd6, 8'h02, "R4 clear sets flag 2");
    // R9 enable off
    wr(3'd0, 8'h10);
    kick(0, 32);
    expect_rd(3'd2, 8'h01, "R9 disabled holds");
    // R8 clear hold
    wr(3'd0, 8'h14);
    kick(0, 32);
    expect_rd(3'd2, 8'h00, "R8 clear holds zero");
    expect_rd(3'd6, 8'h00, "R8 flag 2 reset");
    // R4 divide by 256 from external input
    wr(3'd4, 8'h00);
    wr(3'd0, 8'h31);
    kick(2, 255);
    expect_rd(3'd2, 8'hFF, "R4 count 255 with modulus 0");
    expect_rd(3'd6, 8'h00, "R4 no flag before wrap");
    kick(2, 1);
    expect_rd(3'd2, 8'h00, "R4 wrap clear");
    expect_rd(3'd6, 8'h02, "R4 flag on wrap");
    // R7 tone mode
    wr(3'd0, 8'h24);
    wr(3'd4, 8'd2);
    wr(3'd0, 8'h21);
    kick(1, 5);
    expect_rd(3'd2, 8'h05, "R7 no compare in tone mode");
    expect_rd(3'd6, 8'h00, "R7 flag 2 not set");
    // R6 third counter from in6
    wr(3'd5, 8'd3);
    wr(3'd0, 8'hC2);
    kick(2, 4);
    expect_rd(3'd3, 8'h01, "R6 in6 source");
    expect_rd(3'd6, 8'h04, "R6 flag 3 set");
    expect_pins(3'b100, "R13 fr3 pin");
    wr(3'd0, 8'hCA);
    expect_rd(3'd3, 8'h00, "R8 clear third");
    expect_rd(3'd6, 8'h00, "R8 flag 3 reset");
    // R10/R11 chained
    wr(3'd0, 8'hB5);
    wr(3'd4, 8'd2);
    wr(3'd5, 8'd4);
    wr(3'd0, 8'hB1);
    kick(3, 7);
    expect_rd(3'd2, 8'h01, "R11 in7 selected");
    expect_rd(3'd3, 8'h03, "R6 chained count");
    kick(2, 2);
    kick(4, 2);
    expect_rd(3'd2, 8'h01, "R11 unselected inputs ignored");
    kick(3, 1);
    expect_rd(3'd3, 8'h00, "R4 chained compare clear");
    expect_rd(3'd6, 8'h04, "R10 flag 2 inhibited");
    kick(3, 2);
    expect_rd(3'd3, 8'h01, "R10 chained third counts");
    wr(3'd0, 8'hB2);
    kick(2, 4);
    expect_rd(3'd2, 8'h00, "R10 bit1 no enable T2");
    expect_rd(3'd3, 8'h01, "R10 bit1 no enable T3");
    wr(3'd0, 8'hB5);
    expect_rd(3'd3, 8'h00, "R10 clear2 clears third");
    expect_rd(3'd6, 8'h00, "R10 clear2 resets flag 3");
    wr(3'd0, 8'hB9);
    kick(3, 1);
    kick(4, 1);
    expect_rd(3'd2, 8'h01, "R11 in8 selected");
    done = 1'b1;
    repeat (4) @(posedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule